// File: doc/BRIEF.md
# GPIO and Control Register Bank

This block is a small register-file peripheral for a 16-bit memory-mapped bus. It holds seven writable control words, one fixed status word and a 16-line general-purpose port. Software programs a direction mask and an output level. Sixteen external input lines can also set or clear level bits. The block drives sixteen output lines equal to level AND direction. The outputs are refreshed only when software writes the direction register or the level register.

The bus is a single-cycle register interface with separate write and read strobes and a 6-bit byte address. Registers sit on 32-bit-aligned offsets. A read returns registered data one cycle after the strobe. A system that maps the block into a wider window passes only the low six address bits, so the bank repeats every 64 bytes. An access to an offset with no register, or a write to the read-only status word, makes no change and produces a one-cycle error pulse.

Top module: `gpio_ctl_regfile`

## Requirements
- R1: After reset the status word (offset 0x08) reads 0x0002. Every other register reads 0x0000. `line_out`, `rdata` and `bad_access` are 0.
- R2: The mode (0x00), card-detect (0x04), card-control (0x10), interrupt-request (0x14), interrupt-mask (0x18) and interrupt-status (0x1C) registers store the written 16-bit value unchanged and read it back.
- R3: A write to the power register (0x0C) stores the value. If bit 7 of the written value is 1, bits 15 and 6 of the stored value are also set to 1.
- R4: A write to the status offset 0x08 leaves its value unchanged and raises `bad_access`. A read of 0x08 returns 0x0002 and does not raise `bad_access`.
- R5: A write to offset 0x24 or offset 0x28 stores the written value ANDed with the current direction register in the level register.
- R6: A read of 0x24 or 0x28 returns the level register. A read of 0x20 returns the direction register.
- R7: In the cycle after a write to the direction register (0x20) or the level register (0x24 or 0x28), `line_out` equals level AND direction. `line_out` does not change in any other cycle.
- R8: When bit i of `line_in` changes, level bit i takes the new value on the next clock edge. `line_out` is not recomputed.
- R9: A read of an undefined offset returns 0. A write to an undefined offset changes no register. Either access sets `bad_access` high for exactly the one cycle after the strobe. Undefined offsets are 0x2C to 0x3F and every offset whose two low bits are not 00.
- R10: `rdata` is updated one cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| bad_access | output | 1 | One-cycle pulse after an access to an undefined or read-only offset |
| line_in | input | 16 | External inputs; a change sets or clears the matching level bit |
| line_out | output | 16 | Driven port lines, level AND direction |

## Verification
The assertions check four things on every cycle:
- the output lines stay frozen unless direction or level was written;
- a level write with no input change leaves no bit set outside the direction mask;
- a power write with bit 7 set forces bits 15 and 6;
- read data holds between reads, and every error pulse follows a bus strobe.

Only the bench scenarios can show the remaining behaviour:
- the exact value read from each register;
- the reset pattern of the status word;
- an input change altering the level without moving the outputs;
- an illegal write leaving every register untouched.

// File: rtl/gcr_pkg.sv
// Package gcr_pkg
// Shared constants and types for the GPIO/control register bank.
// Assumes a 16-bit data path and a 6-bit byte offset.
package gcr_pkg;
    localparam int DATA_W = 16;
    localparam int LINES  = 16;
    localparam int OFF_W  = 6;

    localparam logic [DATA_W-1:0] STATUS_RESET = 16'h0002;
    localparam int                PWR_TRIG_BIT = 7;
    localparam logic [DATA_W-1:0] PWR_FORCE    = 16'h8040;

    typedef enum logic [3:0] {
        SEL_MODE, SEL_CDET, SEL_STAT, SEL_PWR, SEL_CCTL,
        SEL_IREQ, SEL_IMSK, SEL_ISTS, SEL_DIR, SEL_LVLW,
        SEL_LVLR, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] cdet;
        logic [DATA_W-1:0] power;
        logic [DATA_W-1:0] cctl;
        logic [DATA_W-1:0] ireq;
        logic [DATA_W-1:0] imask;
        logic [DATA_W-1:0] istat;
    } ctrl_bank_t;
endpackage

// File: rtl/gcr_decode.sv
// Module gcr_decode
// Maps a byte offset to a register selector. Purely combinational.
// Assumes registers sit on 4-byte boundaries. Anything else maps to SEL_NONE.
module gcr_decode
    import gcr_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output reg_sel_e         sel
);
    // Offset lookup
    always_comb begin
        case (off)
            6'h00:   sel = SEL_MODE;
            6'h04:   sel = SEL_CDET;
            6'h08:   sel = SEL_STAT;
            6'h0C:   sel = SEL_PWR;
            6'h10:   sel = SEL_CCTL;
            6'h14:   sel = SEL_IREQ;
            6'h18:   sel = SEL_IMSK;
            6'h1C:   sel = SEL_ISTS;
            6'h20:   sel = SEL_DIR;
            6'h24:   sel = SEL_LVLW;
            6'h28:   sel = SEL_LVLR;
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gcr_ctrl_bank.sv
// Module gcr_ctrl_bank
// Holds the plain control words and applies the power-register force rule.
// Assumes wr_en is already qualified as a legal write by the top.
module gcr_ctrl_bank
    import gcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_bank_t        bank
);
    logic [DATA_W-1:0] pwr_val;

    // Power value with forced bits when the trigger bit is set
    always_comb pwr_val = wdata | (wdata[PWR_TRIG_BIT] ? PWR_FORCE : '0);

    // Register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: bank.mode  <= wdata;
                SEL_CDET: bank.cdet  <= wdata;
                SEL_PWR:  bank.power <= pwr_val;
                SEL_CCTL: bank.cctl  <= wdata;
                SEL_IREQ: bank.ireq  <= wdata;
                SEL_IMSK: bank.imask <= wdata;
                SEL_ISTS: bank.istat <= wdata;
                default:  ;
            endcase
        end
    end

    a_r3_power_force: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_PWR && wdata[PWR_TRIG_BIT])
        |=> (bank.power[15] && bank.power[6]));
endmodule

// File: rtl/gcr_gpio_port.sv
// Module gcr_gpio_port
// Direction, level and driven-output registers of the general-purpose port.
// Assumes dir_we and lvl_we are never high together (they are distinct offsets).
// An input change overrides a same-cycle level write on that bit.
module gcr_gpio_port #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_we,
    input  logic         lvl_we,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] line_in,
    output logic [N-1:0] dir_q,
    output logic [N-1:0] lvl_q,
    output logic [N-1:0] out_q
);
    logic [N-1:0] in_prev;
    logic [N-1:0] in_chg;
    logic [N-1:0] lvl_n;

    // Input change detection
    always_comb in_chg = line_in ^ in_prev;

    // Next level, one bit at a time
    for (genvar i = 0; i < N; i++) begin : g_lvl
        always_comb begin
            if (in_chg[i])   lvl_n[i] = line_in[i];
            else if (lvl_we) lvl_n[i] = wdata[i] & dir_q[i];
            else             lvl_n[i] = lvl_q[i];
        end
    end

    // State update: direction, level, input history, driven outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            lvl_q   <= '0;
            in_prev <= '0;
            out_q   <= '0;
        end else begin
            in_prev <= line_in;
            lvl_q   <= lvl_n;
            if (dir_we) begin
                dir_q <= wdata;
                out_q <= lvl_q & wdata;
            end else if (lvl_we) begin
                out_q <= wdata & dir_q;
            end
        end
    end

    a_r7_out_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(dir_we || lvl_we) |=> $stable(out_q));

    a_r5_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_we && in_chg == '0) |=> ((lvl_q & ~$past(dir_q)) == '0));
endmodule

// File: rtl/gpio_ctl_regfile.sv
// Module gpio_ctl_regfile
// Top of the register bank: decode, read mux, error pulse and submodules.
// Assumes single-cycle strobes. Read data and the error flag are registered.
module gpio_ctl_regfile
    import gcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              bad_access,
    input  logic [LINES-1:0]  line_in,
    output logic [LINES-1:0]  line_out
);
    reg_sel_e          sel;
    ctrl_bank_t        bank;
    logic [LINES-1:0]  dir_q;
    logic [LINES-1:0]  lvl_q;
    logic              wr_legal;
    logic              wr_bad;
    logic              rd_bad;
    logic [DATA_W-1:0] rd_mux;

    gcr_decode u_dec (.off(addr), .sel(sel));

    // Legality of the current access
    always_comb begin
        wr_bad   = wr_en && (sel == SEL_NONE || sel == SEL_STAT);
        wr_legal = wr_en && !wr_bad;
        rd_bad   = rd_en && (sel == SEL_NONE);
    end

    gcr_ctrl_bank u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_legal), .sel(sel),
        .wdata(wdata), .bank(bank)
    );

    gcr_gpio_port #(.N(LINES)) u_gpio (
        .clk(clk), .rst_n(rst_n),
        .dir_we(wr_legal && sel == SEL_DIR),
        .lvl_we(wr_legal && (sel == SEL_LVLW || sel == SEL_LVLR)),
        .wdata(wdata), .line_in(line_in),
        .dir_q(dir_q), .lvl_q(lvl_q), .out_q(line_out)
    );

    // Read data selection
    always_comb begin
        case (sel)
            SEL_MODE: rd_mux = bank.mode;
            SEL_CDET: rd_mux = bank.cdet;
            SEL_STAT: rd_mux = STATUS_RESET;
            SEL_PWR:  rd_mux = bank.power;
            SEL_CCTL: rd_mux = bank.cctl;
            SEL_IREQ: rd_mux = bank.ireq;
            SEL_IMSK: rd_mux = bank.imask;
            SEL_ISTS: rd_mux = bank.istat;
            SEL_DIR:  rd_mux = dir_q;
            SEL_LVLW,
            SEL_LVLR: rd_mux = lvl_q;
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata      <= '0;
            bad_access <= 1'b0;
        end else begin
            if (rd_en) rdata <= rd_mux;
            bad_access <= wr_bad || rd_bad;
        end
    end

    a_r9_bad_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(wr_en || rd_en));

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_gpio_ctl_regfile.sv
`timescale 1ns/1ps
module test_gpio_ctl_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        bad_access;
    logic [15:0] line_in = '0;
    logic [15:0] line_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_ctl_regfile i_gpio_ctl_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .bad_access(bad_access),
        .line_in(line_in), .line_out(line_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // Write; returns at the negedge after the capturing edge
    task automatic wr(input logic [5:0] a, input logic [15:0] d, output logic bad);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        bad = bad_access;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d, output logic bad);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; bad = bad_access;
    endtask

    task automatic t_reset();
        logic [15:0] d; logic b;
        check("R1 line_out", line_out, 16'h0000);
        check("R1 bad_access", {15'b0, bad_access}, 16'h0000);
        check("R1 rdata", rdata, 16'h0000);
        rd(6'h08, d, b); check("R1 status", d, 16'h0002);
        rd(6'h00, d, b); check("R1 mode", d, 16'h0000);
        rd(6'h0C, d, b); check("R1 power", d, 16'h0000);
        rd(6'h20, d, b); check("R1 dir", d, 16'h0000);
        rd(6'h24, d, b); check("R1 level", d, 16'h0000);
    endtask

    task automatic t_ctrl();
        logic [15:0] d; logic b;
        logic [5:0] offs [6] = '{6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C};
        for (int i = 0; i < 6; i++) wr(offs[i], 16'h1111 * (i + 1) ^ 16'h8001, b);
        for (int i = 0; i < 6; i++) begin
            rd(offs[i], d, b);
            check("R2 readback", d, 16'h1111 * (i + 1) ^ 16'h8001);
        end
    endtask

    task automatic t_power();
        logic [15:0] d; logic b;
        wr(6'h0C, 16'h0080, b); rd(6'h0C, d, b); check("R3 trig", d, 16'h80C0);
        wr(6'h0C, 16'h0001, b); rd(6'h0C, d, b); check("R3 no trig", d, 16'h0001);
        wr(6'h0C, 16'h7F3F, b); rd(6'h0C, d, b); check("R3 no trig bits", d, 16'h7F3F);
        wr(6'h0C, 16'h0A81, b); rd(6'h0C, d, b); check("R3 trig mix", d, 16'h8AC1);
    endtask

    task automatic t_status();
        logic [15:0] d; logic b;
        wr(6'h08, 16'hFFFF, b); check("R4 write bad", {15'b0, b}, 16'h0001);
        rd(6'h08, d, b);
        check("R4 value kept", d, 16'h0002);
        check("R4 read ok", {15'b0, b}, 16'h0000);
    endtask

    task automatic t_gpio();
        logic [15:0] d; logic b;
        wr(6'h20, 16'h00FF, b); check("R7 dir write out", line_out, 16'h0000);
        wr(6'h24, 16'hFFFF, b); check("R7 level write out", line_out, 16'h00FF);
        rd(6'h28, d, b); check("R6 read 0x28", d, 16'h00FF);
        rd(6'h24, d, b); check("R5 masked 0x24", d, 16'h00FF);
        wr(6'h28, 16'h0F0F, b); check("R7 out via 0x28", line_out, 16'h000F);
        rd(6'h24, d, b); check("R5 masked 0x28", d, 16'h000F);
        wr(6'h20, 16'hFF00, b); check("R7 dir shrink out", line_out, 16'h0000);
        rd(6'h20, d, b); check("R6 dir read", d, 16'hFF00);
    endtask

    task automatic t_inputs();
        logic [15:0] d; logic b;
        @(negedge clk); line_in = 16'h8000;
        @(negedge clk);
        check("R8 out kept on rise", line_out, 16'h0000);
        rd(6'h28, d, b); check("R8 level set", d, 16'h800F);
        wr(6'h20, 16'hFF00, b); check("R7 refresh", line_out, 16'h8000);
        @(negedge clk); line_in = 16'h0000;
        @(negedge clk);
        check("R8 out kept on fall", line_out, 16'h8000);
        rd(6'h24, d, b); check("R8 level cleared", d, 16'h000F);
    endtask

    task automatic t_bad();
        logic [15:0] d; logic b;
        rd(6'h2C, d, b);
        check("R9 read data", d, 16'h0000); check("R9 read flag", {15'b0, b}, 16'h0001);
        rd(6'h01, d, b); check("R9 unaligned flag", {15'b0, b}, 16'h0001);
        wr(6'h3C, 16'hFFFF, b); check("R9 write flag", {15'b0, b}, 16'h0001);
        @(negedge clk); check("R9 single pulse", {15'b0, bad_access}, 16'h0000);
        wr(6'h22, 16'h1234, b); check("R9 unaligned write flag", {15'b0, b}, 16'h0001);
        rd(6'h20, d, b); check("R9 dir untouched", d, 16'hFF00);
        check("R9 good read no flag", {15'b0, b}, 16'h0000);
        rd(6'h00, d, b); check("R9 mode untouched", d, 16'h1111 ^ 16'h8001);
    endtask

    task automatic t_hold();
        logic [15:0] d; logic b;
        rd(6'h04, d, b); check("R10 read", d, 16'h2222 ^ 16'h8001);
        @(negedge clk); addr = 6'h08;
        @(negedge clk); @(negedge clk);
        check("R10 hold", rdata, 16'h2222 ^ 16'h8001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_power();
        t_status();
        t_gpio();
        t_inputs();
        t_bad();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule